// File: doc/BRIEF.md
# Self-Reloading Compare Event Unit

This block watches two free-running 32-bit counters through four compare channels. Each channel chooses one of the two counters. When that counter reaches the channel's compare value, the channel raises an interrupt request and, if DMA is enabled for it, a DMA request. In the same clock edge the channel adds its update value to the compare value, so it fires again after a fixed number of further counts. Software arms a periodic tick once and then only acknowledges it.

Interrupt, DMA and overflow enables sit in one enable word. That word is written through two addresses: one turns bits on and one turns bits off, so no read-modify-write is needed. A pending word collects the compare events and the counter overflow pulses. Software clears it by writing ones. An interrupt output stays high while its pending bit and its enable are both set.

Top module: `cmpu_top`

## Requirements
- R1: After reset every register reads zero and all interrupt and DMA outputs are low.
- R2: Register map by word address: 0 source select (bit n picks the counter for channel n), 1 enable-set, 2 enable-clear, 3 pending flags, 4+n compare of channel n, 8+n update of channel n. Addresses 1 and 2 both read back the enable word. Unmapped addresses read zero.
- R3: Enable word layout: bits [3:0] interrupt enables for channels 0..3, bits [11:8] DMA enables, bits [17:16] overflow interrupt enables for counters 0 and 1. Other bits always read zero.
- R4: Writing ones to enable-set turns those enable bits on. Writing ones to enable-clear turns them off. Zero bits in either write leave the enables unchanged.
- R5: Source select bit n at 0 ties channel n to counter 0, and at 1 to counter 1. Activity on the other counter never triggers channel n.
- R6: A channel matches only in a cycle where its selected counter's advance strobe is high and the counter value equals the compare value. A match sets pending bit n at the next clock edge.
- R7: On a match the compare value becomes compare plus update, modulo 2^32.
- R8: A software write to a compare register takes effect at once and wins over an auto-update in the same cycle.
- R9: Interrupt output n is high exactly when pending bit n and interrupt enable n are both set.
- R10: A DMA request is a one-cycle pulse in the cycle after a match, issued only if that channel's DMA enable was set in the match cycle.
- R11: An overflow pulse on counter k sets pending bit 16+k. Overflow interrupt k is high when that bit and enable bit 16+k are both set.
- R12: Writing ones to the pending register clears those bits. A bit set by an event in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cnt0_val | input | 32 | Counter 0 value |
| cnt0_adv | input | 1 | Counter 0 holds a newly reached value this cycle |
| cnt1_val | input | 32 | Counter 1 value |
| cnt1_adv | input | 1 | Counter 1 holds a newly reached value this cycle |
| cnt_ovf | input | 2 | Overflow pulse per counter |
| cmp_irq | output | 4 | Compare interrupt per channel |
| cmp_dma | output | 4 | DMA request pulse per channel |
| ovf_irq | output | 2 | Overflow interrupt per counter |

## Verification
The properties assume at most one register write per cycle. They also assume a counter value presented with its advance strobe is new, so a channel never matches twice on one count. Overflow inputs are taken as pulses that stand alone. The bench keeps to this: every write has its own cycle, and the advance strobe is raised for exactly one cycle per value. Combined events, such as a clear or a compare write landing on a match, are built deliberately in one cycle to test the priority rules.

// File: rtl/cmpu_pkg.sv
package cmpu_pkg;
    // register word addresses (R2)
    localparam int ADDR_SRC   = 0;
    localparam int ADDR_ENSET = 1;
    localparam int ADDR_ENCLR = 2;
    localparam int ADDR_FLAG  = 3;
    localparam int ADDR_CMP   = 4;
    localparam int ADDR_UPD   = 8;

    // field positions in the enable and pending words (R3)
    localparam int INT_LSB = 0;
    localparam int DMA_LSB = 8;
    localparam int OVF_LSB = 16;
    localparam int NUM_CNT = 2;

    typedef enum logic {
        SRC_CNT0 = 1'b0,
        SRC_CNT1 = 1'b1
    } cnt_src_e;
endpackage

// File: rtl/cmpu_channel.sv
module cmpu_channel
    import cmpu_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cnt_src_e      src,
    input  logic [CW-1:0] cnt0_val,
    input  logic          cnt0_adv,
    input  logic [CW-1:0] cnt1_val,
    input  logic          cnt1_adv,
    input  logic          cmp_wr,
    input  logic          upd_wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cmp_q,
    output logic [CW-1:0] upd_q,
    output logic          hit
);
    logic [CW-1:0] sel_val;
    logic          sel_adv;

    always_comb begin
        unique case (src)
            SRC_CNT0: begin sel_val = cnt0_val; sel_adv = cnt0_adv; end
            SRC_CNT1: begin sel_val = cnt1_val; sel_adv = cnt1_adv; end
        endcase
        hit = sel_adv && (sel_val == cmp_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            upd_q <= '0;
        end else begin
            if (cmp_wr)
                cmp_q <= wdata;
            else if (hit)
                cmp_q <= cmp_q + upd_q;
            if (upd_wr)
                upd_q <= wdata;
        end
    end
endmodule

// File: rtl/cmpu_regs.sv
module cmpu_regs
    import cmpu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CNT-1:0] ovf,
    output logic [NUM_CH-1:0] src_q,
    output logic [DW-1:0]     en_q,
    output logic [DW-1:0]     flag_q,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] dma_req,
    output logic [NUM_CNT-1:0] ovf_irq
);
    logic [DW-1:0] en_mask, flag_mask, set_vec, clr_vec;
    logic          wr_src, wr_set, wr_clr, wr_flag;

    always_comb begin
        en_mask   = '0;
        flag_mask = '0;
        set_vec   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            en_mask[INT_LSB+i]   = 1'b1;
            en_mask[DMA_LSB+i]   = 1'b1;
            flag_mask[INT_LSB+i] = 1'b1;
            set_vec[INT_LSB+i]   = hit[i];
        end
        for (int k = 0; k < NUM_CNT; k++) begin
            en_mask[OVF_LSB+k]   = 1'b1;
            flag_mask[OVF_LSB+k] = 1'b1;
            set_vec[OVF_LSB+k]   = ovf[k];
        end
        wr_src  = bus_wr && (bus_addr == AW'(ADDR_SRC));
        wr_set  = bus_wr && (bus_addr == AW'(ADDR_ENSET));
        wr_clr  = bus_wr && (bus_addr == AW'(ADDR_ENCLR));
        wr_flag = bus_wr && (bus_addr == AW'(ADDR_FLAG));
        clr_vec = wr_flag ? bus_wdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q   <= '0;
            en_q    <= '0;
            flag_q  <= '0;
            dma_req <= '0;
        end else begin
            if (wr_src)
                src_q <= bus_wdata[NUM_CH-1:0];
            if (wr_set)
                en_q <= en_q | (bus_wdata & en_mask);
            else if (wr_clr)
                en_q <= en_q & ~bus_wdata;
            // a new event wins over a clear in the same cycle
            flag_q  <= ((flag_q & ~clr_vec) | set_vec) & flag_mask;
            dma_req <= hit & en_q[DMA_LSB +: NUM_CH];
        end
    end

    always_comb begin
        irq     = flag_q[INT_LSB +: NUM_CH]  & en_q[INT_LSB +: NUM_CH];
        ovf_irq = flag_q[OVF_LSB +: NUM_CNT] & en_q[OVF_LSB +: NUM_CNT];
    end
endmodule

// File: rtl/cmpu_top.sv
module cmpu_top
    import cmpu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [CW-1:0]     bus_wdata,
    output logic [CW-1:0]     bus_rdata,
    input  logic [CW-1:0]     cnt0_val,
    input  logic              cnt0_adv,
    input  logic [CW-1:0]     cnt1_val,
    input  logic              cnt1_adv,
    input  logic [1:0]        cnt_ovf,
    output logic [NUM_CH-1:0] cmp_irq,
    output logic [NUM_CH-1:0] cmp_dma,
    output logic [1:0]        ovf_irq
);
    logic [NUM_CH-1:0]    hit_vec;
    logic [NUM_CH-1:0]    src_q;
    logic [CW-1:0]        en_q, flag_q;
    logic [CW-1:0]        cmp_arr [NUM_CH];
    logic [CW-1:0]        upd_arr [NUM_CH];
    logic [NUM_CH*CW-1:0] cmp_flat, upd_flat;

    cmpu_regs #(.NUM_CH(NUM_CH), .DW(CW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .hit      (hit_vec),
        .ovf      (cnt_ovf),
        .src_q    (src_q),
        .en_q     (en_q),
        .flag_q   (flag_q),
        .irq      (cmp_irq),
        .dma_req  (cmp_dma),
        .ovf_irq  (ovf_irq)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic cmp_wr, upd_wr;
        assign cmp_wr = bus_wr && (bus_addr == AW'(ADDR_CMP + i));
        assign upd_wr = bus_wr && (bus_addr == AW'(ADDR_UPD + i));

        cmpu_channel #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (cnt_src_e'(src_q[i])),
            .cnt0_val(cnt0_val),
            .cnt0_adv(cnt0_adv),
            .cnt1_val(cnt1_val),
            .cnt1_adv(cnt1_adv),
            .cmp_wr  (cmp_wr),
            .upd_wr  (upd_wr),
            .wdata   (bus_wdata),
            .cmp_q   (cmp_arr[i]),
            .upd_q   (upd_arr[i]),
            .hit     (hit_vec[i])
        );
        assign cmp_flat[i*CW +: CW] = cmp_arr[i];
        assign upd_flat[i*CW +: CW] = upd_arr[i];
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_SRC))
            bus_rdata[NUM_CH-1:0] = src_q;
        if (bus_addr == AW'(ADDR_ENSET) || bus_addr == AW'(ADDR_ENCLR))
            bus_rdata = en_q;
        if (bus_addr == AW'(ADDR_FLAG))
            bus_rdata = flag_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == AW'(ADDR_CMP + i)) bus_rdata = cmp_arr[i];
            if (bus_addr == AW'(ADDR_UPD + i)) bus_rdata = upd_arr[i];
        end
    end
endmodule

// File: rtl/cmpu_checker.sv
module cmpu_checker
    import cmpu_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CW     = 32,
    parameter int AW     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [AW-1:0]        bus_addr,
    input logic [CW-1:0]        bus_wdata,
    input logic [1:0]           cnt_ovf,
    input logic [NUM_CH-1:0]    cmp_dma,
    input logic [NUM_CH-1:0]    hit,
    input logic [CW-1:0]        en_q,
    input logic [CW-1:0]        flag_q,
    input logic [NUM_CH*CW-1:0] cmp_flat,
    input logic [NUM_CH*CW-1:0] upd_flat
);
    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADDR_ENSET)) |=>
        ((en_q[NUM_CH-1:0] & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADDR_ENCLR)) |=>
        ((en_q[NUM_CH-1:0] & $past(bus_wdata[NUM_CH-1:0])) == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7
        auto_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[i] && !(bus_wr && bus_addr == AW'(ADDR_CMP + i))) |=>
            (cmp_flat[i*CW +: CW] == $past(cmp_flat[i*CW +: CW]) + $past(upd_flat[i*CW +: CW])));

        // R8
        sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == AW'(ADDR_CMP + i)) |=>
            (cmp_flat[i*CW +: CW] == $past(bus_wdata)));

        // R10
        dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_dma[i] |-> ($past(hit[i]) && $past(en_q[DMA_LSB+i])));

        // R12
        hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flag_q[i]);
    end

    for (genvar k = 0; k < 2; k++) begin : g_ovf
        // R11
        ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_ovf[k] |=> flag_q[OVF_LSB+k]);
    end
endmodule

bind cmpu_top cmpu_checker #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt_ovf  (cnt_ovf),
    .cmp_dma  (cmp_dma),
    .hit      (hit_vec),
    .en_q     (en_q),
    .flag_q   (flag_q),
    .cmp_flat (cmp_flat),
    .upd_flat (upd_flat)
);

// File: tb/cmpu_top_bench.sv
module cmpu_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] cnt0_val = '0, cnt1_val = '0;
    logic        cnt0_adv = 1'b0, cnt1_adv = 1'b0;
    logic [1:0]  cnt_ovf = '0;
    logic [3:0]  cmp_irq, cmp_dma;
    logic [1:0]  ovf_irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmpu_top u_cmpu_top (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt0_val(cnt0_val), .cnt0_adv(cnt0_adv),
        .cnt1_val(cnt1_val), .cnt1_adv(cnt1_adv),
        .cnt_ovf(cnt_ovf), .cmp_irq(cmp_irq), .cmp_dma(cmp_dma), .ovf_irq(ovf_irq)
    );

    // {channel, source, compare, update, expected compare after the match}
    localparam logic [98:0] VECS [0:5] = '{
        {2'd0, 1'b0, 32'h0000_0010, 32'h0000_0010, 32'h0000_0020},
        {2'd1, 1'b1, 32'h0000_1000, 32'h0000_0400, 32'h0000_1400},
        {2'd2, 1'b0, 32'hFFFF_FFF0, 32'h0000_0020, 32'h0000_0010},
        {2'd3, 1'b1, 32'h1234_5678, 32'h0000_0000, 32'h1234_5678},
        {2'd2, 1'b1, 32'h0000_ABCD, 32'h0000_0001, 32'h0000_ABCE},
        {2'd3, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cnt_step(input logic [31:0] v0, input logic a0,
                            input logic [31:0] v1, input logic a1);
        @(negedge clk);
        cnt0_val = v0; cnt0_adv = a0; cnt1_val = v1; cnt1_adv = a1;
        @(negedge clk);
        cnt0_adv = 1'b0; cnt1_adv = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 map readback of zeros
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            check("R1", d, 32'h0);
        end
        check("R1", {20'h0, cmp_irq, cmp_dma, 2'b0, ovf_irq}, 32'h0);

        // R3/R4 enable set and clear
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); check("R3", d, 32'h0003_0F0F);
        wr(1, 32'h0);
        rd(2, d); check("R4", d, 32'h0003_0F0F);
        wr(2, 32'h0000_0101);
        rd(1, d); check("R4", d, 32'h0003_0E0E);
        wr(2, 32'h0);
        rd(2, d); check("R4", d, 32'h0003_0E0E);
        wr(2, 32'hFFFF_FFFF);
        rd(1, d); check("R4", d, 32'h0);

        // table walk: R5 source select, R7 reload, R10 DMA pulse
        for (int i = 0; i < 6; i++) begin
            logic [1:0]  ch;
            logic        sel;
            logic [31:0] cv, uv, ev;
            {ch, sel, cv, uv, ev} = VECS[i];
            wr(3, 32'hFFFF_FFFF);
            wr(0, 32'(sel) << ch);
            rd(0, d); check("R2", d, 32'(sel) << ch);
            wr(4'(4 + ch), cv);
            wr(4'(8 + ch), uv);
            wr(1, (32'h1 << ch) | (32'h100 << ch));
            wr(3, 32'hFFFF_FFFF);
            // other counter sits on the compare value: must be ignored
            if (sel) cnt_step(cv, 1'b1, cv - 1, 1'b1);
            else     cnt_step(cv - 1, 1'b1, cv, 1'b1);
            rd(3, d); check("R5", d & (32'h1 << ch), 32'h0);
            check("R5", 32'(cmp_dma[ch]), 32'h0);
            if (sel) cnt_step(cv + 5, 1'b1, cv, 1'b1);
            else     cnt_step(cv, 1'b1, cv + 5, 1'b1);
            check("R10", 32'(cmp_dma[ch]), 32'h1);
            check("R9", 32'(cmp_irq[ch]), 32'h1);
            rd(4'(4 + ch), d); check("R7", d, ev);
            @(negedge clk);
            check("R10", 32'(cmp_dma), 32'h0);
            wr(2, 32'hFFFF_FFFF);
        end

        // R6 no match without advance strobe
        wr(0, 32'h0);
        wr(4, 32'd100);
        wr(8, 32'd0);
        wr(1, 32'h1);
        wr(3, 32'hFFFF_FFFF);
        cnt_step(32'd100, 1'b0, 32'd0, 1'b0);
        rd(3, d); check("R6", d & 32'h1, 32'h0);
        cnt_step(32'd100, 1'b1, 32'd0, 1'b0);
        rd(3, d); check("R6", d & 32'h1, 32'h1);
        check("R9", 32'(cmp_irq[0]), 32'h1);
        check("R10", 32'(cmp_dma[0]), 32'h0);

        // R12 event beats a same-cycle clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h1;
        cnt0_val = 32'd100; cnt0_adv = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt0_adv = 1'b0;
        rd(3, d); check("R12", d & 32'h1, 32'h1);
        wr(3, 32'h1);
        rd(3, d); check("R12", d & 32'h1, 32'h0);
        check("R9", 32'(cmp_irq[0]), 32'h0);

        // R9 pending without enable gives no interrupt
        wr(2, 32'h1);
        cnt_step(32'd100, 1'b1, 32'd0, 1'b0);
        rd(3, d); check("R9", d & 32'h1, 32'h1);
        check("R9", 32'(cmp_irq[0]), 32'h0);
        wr(1, 32'h1);
        check("R9", 32'(cmp_irq[0]), 32'h1);

        // R8 software write wins over auto-update
        wr(8, 32'd7);
        wr(3, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'd500;
        cnt0_val = 32'd100; cnt0_adv = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt0_adv = 1'b0;
        rd(4, d); check("R8", d, 32'd500);
        rd(3, d); check("R8", d & 32'h1, 32'h1);

        // R11 overflow flags and interrupts
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        wr(1, 32'h0001_0000);
        @(negedge clk); cnt_ovf = 2'b01;
        @(negedge clk); cnt_ovf = 2'b00;
        rd(3, d); check("R11", d & 32'h0003_0000, 32'h0001_0000);
        check("R11", 32'(ovf_irq), 32'h1);
        @(negedge clk); cnt_ovf = 2'b10;
        @(negedge clk); cnt_ovf = 2'b00;
        rd(3, d); check("R11", d & 32'h0003_0000, 32'h0003_0000);
        check("R11", 32'(ovf_irq), 32'h1);
        wr(3, 32'h0001_0000);
        check("R11", 32'(ovf_irq), 32'h0);
        rd(3, d); check("R12", d & 32'h0003_0000, 32'h0002_0000);

        done = 1'b1;
        finish_run();
    end
endmodule